// File: doc/BRIEF.md
# Banked 24-bit Address Generator

This block turns the addressing information of one memory access of an 8-bit processor into a 24-bit byte address. The sequencer presents an addressing-mode code, a 24-bit operand field, the X and Y index registers, a 16-bit pointer already fetched from memory, the 24-bit program counter and stack pointer, and the 8-bit data bank register. One clock edge later the block returns the effective address. It also says whether the mode needs a pointer fetched from memory first, and it gives the addresses of the low and high bytes of that pointer.

All arithmetic that is not a full 24-bit operation is confined to the low 16 bits. Index and branch offsets never change the top (bank) byte. Zero-page arithmetic is confined further, to the low 8 bits, with the middle byte forced to zero. Only the long-absolute and stack-relative modes choose all 24 bits themselves. The relative branch keeps the program counter's own top byte. Every other mode takes its top byte from the data bank register.

The operand field carries an 8-bit immediate in bits 7:0 and a 16-bit immediate in bits 15:0. A full 24-bit address uses bits 23:0.

Top module: `agen_top`

## Requirements
- R1: A request sampled with `req_valid_i` high at a rising edge gives `addr_valid_o` high after that edge. With `req_valid_i` low, `addr_valid_o` is low after the edge, and `addr_o`, `need_ptr_o`, `ptr_lo_o` and `ptr_hi_o` keep their values.
- R2: Mode 0 (absolute) gives `{bank, imm16}`. The unused mode code 15 behaves exactly like mode 0.
- R3: Modes 1 and 2 (absolute indexed by X or Y) give `{bank, (imm16 + index) mod 2^16}`. A carry out of bit 15 is dropped and the top byte stays equal to the bank register.
- R4: Modes 3, 4 and 5 (zero page, zero page + X, zero page + Y) give `{bank, 8'h00, (imm8 + index) mod 256}`. Mode 3 adds no index.
- R5: Mode 6 (long absolute) gives the 24-bit operand unchanged, with no bank substitution.
- R6: Mode 7 (stack relative) gives `(SP + zero-extended imm8) mod 2^24`, with the carry free to reach bits 23:16.
- R7: Modes 8, 9 and 10 (pointer at an absolute location; no index, X, Y) and modes 11, 12 and 13 (pointer at a zero-page location; no index, X, Y) give `{bank, (ptr + index) mod 2^16}`. These modes assert `need_ptr_o`. All other modes clear it.
- R8: For modes 8 to 10 the pointer's low byte is at `{bank, imm16}` and its high byte at `{bank, (imm16+1) mod 2^16}`. For modes 11 to 13 they are at `{bank, 8'h00, imm8}` and `{bank, 8'h00, (imm8+1) mod 256}`. In every other mode both pointer addresses are zero.
- R9: Mode 14 (relative branch) gives `{PC[23:16], (PC[15:0] + sign-extended imm8) mod 2^16}`.
- R10: While reset is held, and after it until the first request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| mode_i | input | 4 | Addressing-mode code (0 to 15) |
| opnd_i | input | 24 | Operand field: imm8 in 7:0, imm16 in 15:0, long address in 23:0 |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| ptr_i | input | 16 | Pointer fetched from memory for indirect modes |
| pc_i | input | 24 | Program counter |
| sp_i | input | 24 | Stack pointer |
| bank_i | input | 8 | Data bank register |
| addr_valid_o | output | 1 | Registered outputs belong to a request |
| addr_o | output | 24 | Effective byte address |
| need_ptr_o | output | 1 | Mode reads a pointer from memory first |
| ptr_lo_o | output | 24 | Address of the pointer's low byte |
| ptr_hi_o | output | 24 | Address of the pointer's high byte |

## Verification
The hardest behaviour to reach is a carry that stops at a byte boundary. Uniform random operands rarely put a low field at all-ones with an index large enough to cross it. That case decides whether the bank byte or the zero-page middle byte stays untouched. The stimulus therefore mixes random requests with directed ones: imm16 at 0xFFFF plus an index, a zero-page byte at 0xFF, a pointer location at the top of a 16-bit page, a negative branch offset from a program counter near 0x0000, and a stack pointer whose carry runs into the top byte. Idle cycles with scrambled inputs sit between requests and show that the outputs hold.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [3:0] {
        MODE_ABS      = 4'd0,
        MODE_ABS_X    = 4'd1,
        MODE_ABS_Y    = 4'd2,
        MODE_ZP       = 4'd3,
        MODE_ZP_X     = 4'd4,
        MODE_ZP_Y     = 4'd5,
        MODE_LONG     = 4'd6,
        MODE_STK      = 4'd7,
        MODE_IND      = 4'd8,
        MODE_IND_X    = 4'd9,
        MODE_IND_Y    = 4'd10,
        MODE_ZIND     = 4'd11,
        MODE_ZIND_X   = 4'd12,
        MODE_ZIND_Y   = 4'd13,
        MODE_REL      = 4'd14,
        MODE_SPARE    = 4'd15
    } agen_mode_e;

    typedef enum logic [2:0] {
        BASE_ABS  = 3'd0,
        BASE_ZP   = 3'd1,
        BASE_LONG = 3'd2,
        BASE_STK  = 3'd3,
        BASE_PTR  = 3'd4,
        BASE_REL  = 3'd5
    } agen_base_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_X    = 2'd1,
        IDX_Y    = 2'd2
    } agen_idx_e;

    typedef struct packed {
        agen_base_e base;
        agen_idx_e  idx;
        logic       indirect;
        logic       ptr_zp;
    } agen_ctl_t;

endpackage

// File: rtl/agen_decode.sv
module agen_decode
    import agen_pkg::*;
(
    input  agen_mode_e mode,
    output agen_ctl_t  ctl
);

    always_comb begin
        ctl          = '0;
        ctl.base     = BASE_ABS;
        ctl.idx      = IDX_NONE;
        ctl.indirect = 1'b0;
        ctl.ptr_zp   = 1'b0;
        case (mode)
            MODE_ABS_X:  ctl.idx = IDX_X;
            MODE_ABS_Y:  ctl.idx = IDX_Y;
            MODE_ZP:     ctl.base = BASE_ZP;
            MODE_ZP_X: begin
                ctl.base = BASE_ZP;
                ctl.idx  = IDX_X;
            end
            MODE_ZP_Y: begin
                ctl.base = BASE_ZP;
                ctl.idx  = IDX_Y;
            end
            MODE_LONG:   ctl.base = BASE_LONG;
            MODE_STK:    ctl.base = BASE_STK;
            MODE_IND, MODE_IND_X, MODE_IND_Y,
            MODE_ZIND, MODE_ZIND_X, MODE_ZIND_Y: begin
                ctl.base     = BASE_PTR;
                ctl.indirect = 1'b1;
                ctl.ptr_zp   = (mode == MODE_ZIND) || (mode == MODE_ZIND_X)
                            || (mode == MODE_ZIND_Y);
                if (mode == MODE_IND_X || mode == MODE_ZIND_X)
                    ctl.idx = IDX_X;
                else if (mode == MODE_IND_Y || mode == MODE_ZIND_Y)
                    ctl.idx = IDX_Y;
                else
                    ctl.idx = IDX_NONE;
            end
            MODE_REL:    ctl.base = BASE_REL;
            default:     ctl.base = BASE_ABS;
        endcase
    end

endmodule

// File: rtl/agen_wrap_add.sv
module agen_wrap_add #(
    parameter int W        = 16,
    parameter int BW       = 8,
    parameter bit SIGN_EXT = 1'b0
) (
    input  logic [W-1:0]  a,
    input  logic [BW-1:0] b,
    output logic [W-1:0]  sum
);

    logic [W-1:0] b_ext;

    generate
        if (W == BW) begin : g_same
            assign b_ext = b;
        end else if (SIGN_EXT) begin : g_sext
            assign b_ext = {{(W-BW){b[BW-1]}}, b};
        end else begin : g_zext
            assign b_ext = {{(W-BW){1'b0}}, b};
        end
    endgenerate

    assign sum = a + b_ext;

endmodule

// File: rtl/agen_ptr_loc.sv
module agen_ptr_loc #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    parameter int ZP_W   = 8,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic              en,
    input  logic              zp,
    input  logic [BANK_W-1:0] bank,
    input  logic [OFF_W-1:0]  loc,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);

    logic [OFF_W-1:0] loc_next;
    logic [ZP_W-1:0]  zp_next;

    agen_wrap_add #(.W(OFF_W), .BW(1), .SIGN_EXT(1'b0)) u_inc_abs (
        .a   (loc),
        .b   (1'b1),
        .sum (loc_next)
    );

    agen_wrap_add #(.W(ZP_W), .BW(1), .SIGN_EXT(1'b0)) u_inc_zp (
        .a   (loc[ZP_W-1:0]),
        .b   (1'b1),
        .sum (zp_next)
    );

    always_comb begin
        lo = '0;
        hi = '0;
        if (en) begin
            if (zp) begin
                lo = {bank, {(OFF_W-ZP_W){1'b0}}, loc[ZP_W-1:0]};
                hi = {bank, {(OFF_W-ZP_W){1'b0}}, zp_next};
            end else begin
                lo = {bank, loc};
                hi = {bank, loc_next};
            end
        end
    end

endmodule

// File: rtl/agen_top.sv
module agen_top
    import agen_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = BANK_W + OFF_W,
    localparam int MID_W  = OFF_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [3:0]        mode_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic [BYTE_W-1:0] idx_x_i,
    input  logic [BYTE_W-1:0] idx_y_i,
    input  logic [OFF_W-1:0]  ptr_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic              addr_valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              need_ptr_o,
    output logic [ADDR_W-1:0] ptr_lo_o,
    output logic [ADDR_W-1:0] ptr_hi_o
);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              need_ptr;
        logic [ADDR_W-1:0] ptr_lo;
        logic [ADDR_W-1:0] ptr_hi;
    } agen_state_t;

    agen_state_t st_d, st_q;
    agen_ctl_t   ctl;

    logic [BYTE_W-1:0] imm8;
    logic [OFF_W-1:0]  imm16;
    logic [BYTE_W-1:0] idx_val;
    logic [OFF_W-1:0]  base16;
    logic [OFF_W-1:0]  sum_ix16;
    logic [BYTE_W-1:0] sum_zp;
    logic [OFF_W-1:0]  sum_rel;
    logic [ADDR_W-1:0] sum_stk;
    logic [ADDR_W-1:0] ptr_lo_w;
    logic [ADDR_W-1:0] ptr_hi_w;
    logic [ADDR_W-1:0] eff_addr;

    assign imm8  = opnd_i[BYTE_W-1:0];
    assign imm16 = opnd_i[OFF_W-1:0];

    agen_decode u_decode (
        .mode (agen_mode_e'(mode_i)),
        .ctl  (ctl)
    );

    always_comb begin
        case (ctl.idx)
            IDX_X:   idx_val = idx_x_i;
            IDX_Y:   idx_val = idx_y_i;
            default: idx_val = '0;
        endcase
        base16 = (ctl.base == BASE_PTR) ? ptr_i : imm16;
    end

    // Low 16 bits only: the carry out of the top bit is dropped, bank untouched
    agen_wrap_add #(.W(OFF_W), .BW(BYTE_W), .SIGN_EXT(1'b0)) u_add_ix (
        .a   (base16),
        .b   (idx_val),
        .sum (sum_ix16)
    );

    // Zero-page sum wraps within one byte
    agen_wrap_add #(.W(BYTE_W), .BW(BYTE_W), .SIGN_EXT(1'b0)) u_add_zp (
        .a   (imm8),
        .b   (idx_val),
        .sum (sum_zp)
    );

    // Branch displacement is signed and stays inside the current bank
    agen_wrap_add #(.W(OFF_W), .BW(BYTE_W), .SIGN_EXT(1'b1)) u_add_rel (
        .a   (pc_i[OFF_W-1:0]),
        .b   (imm8),
        .sum (sum_rel)
    );

    // Stack offset is unsigned and may carry through all 24 bits
    agen_wrap_add #(.W(ADDR_W), .BW(BYTE_W), .SIGN_EXT(1'b0)) u_add_stk (
        .a   (sp_i),
        .b   (imm8),
        .sum (sum_stk)
    );

    agen_ptr_loc #(.BANK_W(BANK_W), .OFF_W(OFF_W), .ZP_W(BYTE_W)) u_ptr_loc (
        .en   (ctl.indirect),
        .zp   (ctl.ptr_zp),
        .bank (bank_i),
        .loc  (imm16),
        .lo   (ptr_lo_w),
        .hi   (ptr_hi_w)
    );

    always_comb begin
        case (ctl.base)
            BASE_ZP:   eff_addr = {bank_i, {MID_W{1'b0}}, sum_zp};
            BASE_LONG: eff_addr = opnd_i;
            BASE_STK:  eff_addr = sum_stk;
            BASE_REL:  eff_addr = {pc_i[ADDR_W-1:OFF_W], sum_rel};
            default:   eff_addr = {bank_i, sum_ix16};
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid_i;
        if (req_valid_i) begin
            st_d.addr     = eff_addr;
            st_d.need_ptr = ctl.indirect;
            st_d.ptr_lo   = ptr_lo_w;
            st_d.ptr_hi   = ptr_hi_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_valid_o = st_q.vld;
    assign addr_o       = st_q.addr;
    assign need_ptr_o   = st_q.need_ptr;
    assign ptr_lo_o     = st_q.ptr_lo;
    assign ptr_hi_o     = st_q.ptr_hi;

    p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> addr_valid_o);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!addr_valid_o && $stable(addr_o) && $stable(ptr_lo_o)
                          && $stable(ptr_hi_o) && $stable(need_ptr_o)));

    p_bank_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(mode_i inside {MODE_LONG, MODE_STK, MODE_REL}))
        |=> (addr_o[ADDR_W-1 -: BANK_W] == $past(bank_i)));

    p_zp_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (mode_i inside {MODE_ZP, MODE_ZP_X, MODE_ZP_Y}))
        |=> (addr_o[OFF_W-1:BYTE_W] == '0));

    p_long_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode_i == MODE_LONG) |=> (addr_o == $past(opnd_i)));

    p_need_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (need_ptr_o == ($past(mode_i) inside
            {MODE_IND, MODE_IND_X, MODE_IND_Y, MODE_ZIND, MODE_ZIND_X, MODE_ZIND_Y})));

    p_ptr_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && need_ptr_o)
        |-> (ptr_lo_o[ADDR_W-1 -: BANK_W] == ptr_hi_o[ADDR_W-1 -: BANK_W]));

    p_ptr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !need_ptr_o) |-> (ptr_lo_o == '0 && ptr_hi_o == '0));

    p_rel_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && mode_i == MODE_REL)
        |=> (addr_o[ADDR_W-1 -: BANK_W] == $past(pc_i[ADDR_W-1 -: BANK_W])));

endmodule

// File: tb/test_agen_top.sv
module test_agen_top;

    logic        clk;
    logic        rst_n;
    logic        req_valid_i;
    logic [3:0]  mode_i;
    logic [23:0] opnd_i;
    logic [7:0]  idx_x_i;
    logic [7:0]  idx_y_i;
    logic [15:0] ptr_i;
    logic [23:0] pc_i;
    logic [23:0] sp_i;
    logic [7:0]  bank_i;
    logic        addr_valid_o;
    logic [23:0] addr_o;
    logic        need_ptr_o;
    logic [23:0] ptr_lo_o;
    logic [23:0] ptr_hi_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [23:0] last_addr, last_lo, last_hi;
    logic        last_need;

    agen_top i_agen_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .mode_i       (mode_i),
        .opnd_i       (opnd_i),
        .idx_x_i      (idx_x_i),
        .idx_y_i      (idx_y_i),
        .ptr_i        (ptr_i),
        .pc_i         (pc_i),
        .sp_i         (sp_i),
        .bank_i       (bank_i),
        .addr_valid_o (addr_valid_o),
        .addr_o       (addr_o),
        .need_ptr_o   (need_ptr_o),
        .ptr_lo_o     (ptr_lo_o),
        .ptr_hi_o     (ptr_hi_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0, 4'd15:       return "R2";
            4'd1, 4'd2:        return "R3";
            4'd3, 4'd4, 4'd5:  return "R4";
            4'd6:              return "R5";
            4'd7:              return "R6";
            4'd14:             return "R9";
            default:           return "R7";
        endcase
    endfunction

    function automatic logic [7:0] pick_idx(input logic [3:0] m, input logic [7:0] x,
                                            input logic [7:0] y);
        if (m == 4'd1 || m == 4'd4 || m == 4'd9 || m == 4'd12) return x;
        if (m == 4'd2 || m == 4'd5 || m == 4'd10 || m == 4'd13) return y;
        return 8'h00;
    endfunction

    function automatic logic [23:0] exp_addr(input logic [3:0] m, input logic [23:0] op,
            input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
            input logic [23:0] pc, input logic [23:0] sp, input logic [7:0] bk);
        logic [16:0] t17;
        logic [8:0]  t9;
        logic [24:0] t25;
        logic [7:0]  ix;
        ix = pick_idx(m, x, y);
        case (m)
            4'd1, 4'd2: begin
                t17 = {1'b0, op[15:0]} + {9'd0, ix};
                return {bk, t17[15:0]};
            end
            4'd3, 4'd4, 4'd5: begin
                t9 = {1'b0, op[7:0]} + {1'b0, ix};
                return {bk, 8'h00, t9[7:0]};
            end
            4'd6: return op;
            4'd7: begin
                t25 = {1'b0, sp} + {17'd0, op[7:0]};
                return t25[23:0];
            end
            4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13: begin
                t17 = {1'b0, p} + {9'd0, ix};
                return {bk, t17[15:0]};
            end
            4'd14: begin
                t17 = {1'b0, pc[15:0]} + {{9{op[7]}}, op[7:0]};
                return {pc[23:16], t17[15:0]};
            end
            default: return {bk, op[15:0]};
        endcase
    endfunction

    function automatic logic exp_need(input logic [3:0] m);
        return (m >= 4'd8) && (m <= 4'd13);
    endfunction

    function automatic logic [23:0] exp_lo(input logic [3:0] m, input logic [23:0] op,
                                           input logic [7:0] bk);
        if (m >= 4'd8 && m <= 4'd10) return {bk, op[15:0]};
        if (m >= 4'd11 && m <= 4'd13) return {bk, 8'h00, op[7:0]};
        return 24'h0;
    endfunction

    function automatic logic [23:0] exp_hi(input logic [3:0] m, input logic [23:0] op,
                                           input logic [7:0] bk);
        logic [15:0] n16;
        logic [7:0]  n8;
        n16 = op[15:0] + 16'd1;
        n8  = op[7:0] + 8'd1;
        if (m >= 4'd8 && m <= 4'd10) return {bk, n16};
        if (m >= 4'd11 && m <= 4'd13) return {bk, 8'h00, n8};
        return 24'h0;
    endfunction

    task automatic check(input string rq, input string what, input logic [23:0] act,
                         input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%06h expected=%06h", rq, what, act, exp);
        end
    endtask

    // Called at a falling edge; result is sampled at the next falling edge
    task automatic send(input logic [3:0] m, input logic [23:0] op, input logic [7:0] x,
                        input logic [7:0] y, input logic [15:0] p, input logic [23:0] pc,
                        input logic [23:0] sp, input logic [7:0] bk);
        logic [23:0] ea, el, eh;
        logic        en;
        string       rq;
        req_valid_i = 1'b1;
        mode_i = m; opnd_i = op; idx_x_i = x; idx_y_i = y;
        ptr_i = p; pc_i = pc; sp_i = sp; bank_i = bk;
        ea = exp_addr(m, op, x, y, p, pc, sp, bk);
        en = exp_need(m);
        el = exp_lo(m, op, bk);
        eh = exp_hi(m, op, bk);
        rq = req_of(m);
        @(negedge clk);
        check("R1", "valid", {23'd0, addr_valid_o}, 24'd1);
        check(rq, "addr", addr_o, ea);
        check("R7", "need_ptr", {23'd0, need_ptr_o}, {23'd0, en});
        check("R8", "ptr_lo", ptr_lo_o, el);
        check("R8", "ptr_hi", ptr_hi_o, eh);
        last_addr = ea; last_lo = el; last_hi = eh; last_need = en;
        req_valid_i = 1'b0;
    endtask

    // R1: idle cycle with scrambled inputs must leave outputs unchanged
    task automatic idle();
        req_valid_i = 1'b0;
        mode_i  = 4'($urandom);
        opnd_i  = 24'($urandom);
        idx_x_i = 8'($urandom);
        idx_y_i = 8'($urandom);
        ptr_i   = 16'($urandom);
        pc_i    = 24'($urandom);
        sp_i    = 24'($urandom);
        bank_i  = 8'($urandom);
        @(negedge clk);
        check("R1", "idle valid", {23'd0, addr_valid_o}, 24'd0);
        check("R1", "idle addr", addr_o, last_addr);
        check("R1", "idle lo", ptr_lo_o, last_lo);
        check("R1", "idle hi", ptr_hi_o, last_hi);
        check("R1", "idle need", {23'd0, need_ptr_o}, {23'd0, last_need});
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        req_valid_i = 1'b0;
        mode_i = '0; opnd_i = '0; idx_x_i = '0; idx_y_i = '0;
        ptr_i = '0; pc_i = '0; sp_i = '0; bank_i = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "reset valid", {23'd0, addr_valid_o}, 24'd0);
        check("R10", "reset addr", addr_o, 24'd0);
        check("R10", "reset need", {23'd0, need_ptr_o}, 24'd0);
        check("R10", "reset lo", ptr_lo_o, 24'd0);
        check("R10", "reset hi", ptr_hi_o, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "post-reset addr", addr_o, 24'd0);
        last_addr = '0; last_lo = '0; last_hi = '0; last_need = 1'b0;

        // R2: absolute and spare code
        send(4'd0,  24'hAB1234, 8'h11, 8'h22, 16'h0, 24'h0, 24'h0, 8'h5A);
        send(4'd15, 24'hCD4321, 8'h11, 8'h22, 16'h0, 24'h0, 24'h0, 8'h3C);
        // R3: carry into middle byte, and no carry into bank
        send(4'd1,  24'h0012FF, 8'h01, 8'h00, 16'h0, 24'h0, 24'h0, 8'h07);
        send(4'd2,  24'h00FFF0, 8'h00, 8'h20, 16'h0, 24'h0, 24'h0, 8'h07);
        idle();
        // R4: zero-page wrap stays in low byte
        send(4'd4,  24'h1234FF, 8'h02, 8'h00, 16'h0, 24'h0, 24'h0, 8'h44);
        send(4'd5,  24'h000080, 8'h00, 8'hFF, 16'h0, 24'h0, 24'h0, 8'h44);
        send(4'd3,  24'hFFFF9A, 8'hFF, 8'hFF, 16'h0, 24'h0, 24'h0, 8'h01);
        // R5: long absolute ignores bank
        send(4'd6,  24'hFEDCBA, 8'h00, 8'h00, 16'h0, 24'h0, 24'h0, 8'h12);
        // R6: stack carry into top byte
        send(4'd7,  24'h000080, 8'h00, 8'h00, 16'h0, 24'h0, 24'h00FFFF, 8'h12);
        send(4'd7,  24'h0000FF, 8'h00, 8'h00, 16'h0, 24'h0, 24'hFFFFFF, 8'h12);
        idle();
        // R7 / R8: pointer location at page edges, index wrapping the pointer
        send(4'd10, 24'h00FFFF, 8'h00, 8'h10, 16'hFFF8, 24'h0, 24'h0, 8'h09);
        send(4'd11, 24'h0000FF, 8'h00, 8'h00, 16'h2000, 24'h0, 24'h0, 8'h09);
        send(4'd12, 24'h0000FF, 8'hFF, 8'h00, 16'hFF01, 24'h0, 24'h0, 8'h77);
        // R9: negative offset below 0x0000 and positive wrap, bank kept
        send(4'd14, 24'h0000FC, 8'h00, 8'h00, 16'h0, 24'h050002, 24'h0, 8'h00);
        send(4'd14, 24'h00007F, 8'h00, 8'h00, 16'h0, 24'h07FFF0, 24'h0, 8'h00);
        send(4'd14, 24'h000080, 8'h00, 8'h00, 16'h0, 24'h020100, 24'h0, 8'h00);
        idle();

        for (int i = 0; i < 400; i++) begin
            send(4'($urandom), 24'($urandom), 8'($urandom), 8'($urandom),
                 16'($urandom), 24'($urandom), 24'($urandom), 8'($urandom));
            if (($urandom % 5) == 0) idle();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule